// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside the CPU of an 8-bit microcontroller and decides when the core is held in reset and which clocks run. It takes the external reset pin, which is asynchronous to the oscillator. The pin is passed through a synchronizer and looked at once per machine cycle, at a fixed oscillator phase. Only after enough consecutive high samples does the block assert the core reset. At that moment it emits a one-cycle load pulse, so that the special function registers take their reset values.

The block also owns the power control byte. Two of its bits select the low-power modes. In Idle only the CPU clock is gated: peripherals, timers and the interrupt logic keep running, and any enabled interrupt ends the mode. In Power-down the oscillator is stopped, and only the reset pin can end the mode. Each mode forces its own level onto the address latch and program store strobes. Two flag bits and one spare bit are plain storage that software uses to tell why it woke up.

Top module: `rpm_ctrl`

## Requirements
- R1: After the power-on reset `rst_n`, `pcon_rdata` reads 00h, `cpu_clk_en`, `periph_clk_en` and `osc_run_en` are 1, `strobe_hold_en` is 0, and `core_rst` and `sfr_load` are 0.
- R2: `rst_pin` passes a two-flop synchronizer and is sampled once per machine cycle of `OSC_PER_MC` (12) clocks. When `REQ_SAMPLES` (2) consecutive samples are high, `core_rst` rises and `sfr_load` is high for exactly one clock. `core_rst` falls at the first low sample.
- R3: A pin pulse shorter than one machine cycle gives at most one high sample. It causes no `sfr_load` pulse, no `core_rst`, and no change to `pcon_rdata`.
- R4: A core reset clears the whole power control byte to 00h, including the flags and the spare bit. It therefore ends both Idle and Power-down.
- R5: The power control byte uses these bits: bit0 is Idle, bit1 is Power-down, bits 3:2 are software flags and bit7 is a spare stored bit. Bits 6:4 always read 0. A write (`pcon_we`, `pcon_wdata`) is taken only while neither mode bit is set and `core_rst` is low.
- R6: With bit0 set and bit1 clear (Idle), `cpu_clk_en` is 0 while `periph_clk_en` and `osc_run_en` stay 1. `strobe_hold_en` is 1 and `strobe_hold_lvl` is 1 (strobes held high).
- R7: In Idle, a high `int_pend` at a clock edge clears bit0 at that edge and keeps every other bit. The CPU clock then runs again.
- R8: With bit1 set (Power-down, also when bit0 is set too), `cpu_clk_en`, `periph_clk_en` and `osc_run_en` are 0. `strobe_hold_en` is 1 and `strobe_hold_lvl` is 0 (strobes held low).
- R9: In Power-down, `int_pend` has no effect, and the mode ends only through a core reset. While `rst_pin` is high, `osc_run_en` is 1 without waiting for a clock edge.
- R10: In Idle, writes to the power control byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| pcon_we | input | 1 | CPU write strobe for the power control byte |
| pcon_wdata | input | 8 | Write data for the power control byte |
| int_pend | input | 1 | An enabled interrupt is pending |
| pcon_rdata | output | 8 | Current power control byte |
| core_rst | output | 1 | Qualified core reset level |
| sfr_load | output | 1 | One-cycle pulse that loads register reset values |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Timer, serial and interrupt clock enable |
| osc_run_en | output | 1 | Oscillator run enable |
| strobe_hold_en | output | 1 | Override the bus strobes |
| strobe_hold_lvl | output | 1 | Level forced on the strobes when overridden |

## Verification
Reset pulses are drawn in two length bands, well under one machine cycle and over three machine cycles. Counting `sfr_load` pulses across these separates qualified resets from glitches, whatever the pulse phase. Random write bytes set every mix of mode bits, flags and unused bits. This shows that Power-down wins when both mode bits are set and that unused bits read as zero. Each mode is then probed with an interrupt and with a stray write. The outcomes tell an Idle wakeup from Power-down, which ignores the interrupt, and show that writes are locked out while the CPU clock is stopped.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int PCON_W = 8;
  localparam int BIT_IDLE = 0;
  localparam int BIT_DOWN = 1;
  localparam logic [PCON_W-1:0] PCON_IMPL = 8'h8F;
  localparam logic [PCON_W-1:0] PCON_RST  = 8'h00;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2
  } pmode_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic osc_en;
    logic hold_en;
    logic hold_lvl;
  } clkctl_t;
endpackage

// File: rtl/rpm_rst_sampler.sv
module rpm_rst_sampler #(
  parameter int OSC_PER_MC  = 12,
  parameter int SAMPLE_PH   = 5,
  parameter int REQ_SAMPLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic run_i,
  output logic core_rst_o,
  output logic load_o
);
  localparam int PH_W  = (OSC_PER_MC > 1) ? $clog2(OSC_PER_MC) : 1;
  localparam int CNT_W = $clog2(REQ_SAMPLES + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSC_PER_MC - 1);
  localparam logic [PH_W-1:0]  PH_SAMP = PH_W'(SAMPLE_PH);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REQ_SAMPLES);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [PH_W-1:0]        ph_q, ph_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   rst_q, rst_d;
  logic                   load_q, load_d;
  logic                   pin_s, adv, samp;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end else begin : g_single
      assign sync_d = pin_i;
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign adv   = run_i | pin_s;
  assign samp  = adv & (ph_q == PH_SAMP);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    rst_d  = rst_q;
    load_d = 1'b0;
    if (adv) begin
      ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
    if (samp) begin
      if (pin_s) begin
        if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + 1'b1;
        end
        if (cnt_d == CNT_MAX) begin
          rst_d  = 1'b1;
          load_d = ~rst_q;
        end
      end else begin
        cnt_d = '0;
        rst_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
      rst_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      rst_q  <= rst_d;
      load_q <= load_d;
    end
  end

  assign core_rst_o = rst_q;
  assign load_o     = load_q;
endmodule

// File: rtl/rpm_pcon_reg.sv
module rpm_pcon_reg
  import rpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst_i,
  input  logic              we_i,
  input  logic              wr_ok_i,
  input  logic [PCON_W-1:0] wdata_i,
  input  logic              wake_i,
  output logic [PCON_W-1:0] pcon_o
);
  logic [PCON_W-1:0] pcon_q, pcon_d;

  always_comb begin
    pcon_d = pcon_q;
    if (core_rst_i) begin
      pcon_d = PCON_RST;
    end else if (we_i && wr_ok_i) begin
      pcon_d = wdata_i & PCON_IMPL;
    end else if (wake_i && pcon_q[BIT_IDLE] && !pcon_q[BIT_DOWN]) begin
      pcon_d[BIT_IDLE] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcon_q <= PCON_RST;
    end else begin
      pcon_q <= pcon_d;
    end
  end

  assign pcon_o = pcon_q;
endmodule

// File: rtl/rpm_mode_dec.sv
module rpm_mode_dec
  import rpm_pkg::*;
(
  input  logic [PCON_W-1:0] pcon_i,
  input  logic              pin_i,
  output pmode_e            mode_o,
  output clkctl_t           ctl_o
);
  always_comb begin
    if (pcon_i[BIT_DOWN]) begin
      mode_o = MODE_DOWN;
    end else if (pcon_i[BIT_IDLE]) begin
      mode_o = MODE_IDLE;
    end else begin
      mode_o = MODE_RUN;
    end
  end

  always_comb begin
    ctl_o = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1,
              hold_en: 1'b0, hold_lvl: 1'b0};
    unique case (mode_o)
      MODE_IDLE: begin
        ctl_o.cpu_en   = 1'b0;
        ctl_o.hold_en  = 1'b1;
        ctl_o.hold_lvl = 1'b1;
      end
      MODE_DOWN: begin
        ctl_o.cpu_en   = 1'b0;
        ctl_o.per_en   = 1'b0;
        ctl_o.osc_en   = pin_i;
        ctl_o.hold_en  = 1'b1;
        ctl_o.hold_lvl = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int SAMPLE_PH   = 5,
  parameter int REQ_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin,
  input  logic       pcon_we,
  input  logic [7:0] pcon_wdata,
  input  logic       int_pend,
  output logic [7:0] pcon_rdata,
  output logic       core_rst,
  output logic       sfr_load,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_run_en,
  output logic       strobe_hold_en,
  output logic       strobe_hold_lvl
);
  pmode_e            mode;
  clkctl_t           ctl;
  logic [PCON_W-1:0] pcon;
  logic              rst_int, load_int, wr_ok;

  rpm_rst_sampler #(
    .OSC_PER_MC (OSC_PER_MC),
    .SAMPLE_PH  (SAMPLE_PH),
    .REQ_SAMPLES(REQ_SAMPLES),
    .SYNC_STAGES(2)
  ) i_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (rst_pin),
    .run_i     (mode != MODE_DOWN),
    .core_rst_o(rst_int),
    .load_o    (load_int)
  );

  assign wr_ok = (mode == MODE_RUN) && !rst_int;

  rpm_pcon_reg i_pcon (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_rst_i(rst_int),
    .we_i      (pcon_we),
    .wr_ok_i   (wr_ok),
    .wdata_i   (pcon_wdata),
    .wake_i    (int_pend),
    .pcon_o    (pcon)
  );

  rpm_mode_dec i_dec (
    .pcon_i(pcon),
    .pin_i (rst_pin),
    .mode_o(mode),
    .ctl_o (ctl)
  );

  assign pcon_rdata      = pcon;
  assign core_rst        = rst_int;
  assign sfr_load        = load_int;
  assign cpu_clk_en      = ctl.cpu_en;
  assign periph_clk_en   = ctl.per_en;
  assign osc_run_en      = ctl.osc_en;
  assign strobe_hold_en  = ctl.hold_en;
  assign strobe_hold_lvl = ctl.hold_lvl;
endmodule

// File: rtl/rpm_ctrl_chk.sv
module rpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin,
  input logic       pcon_we,
  input logic [7:0] pcon_wdata,
  input logic       int_pend,
  input logic [7:0] pcon_rdata,
  input logic       core_rst,
  input logic       sfr_load,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_run_en,
  input logic       strobe_hold_en,
  input logic       strobe_hold_lvl
);
  assert_run_clocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pcon_rdata[1:0] == 2'b00) |-> (cpu_clk_en && periph_clk_en && !strobe_hold_en));

  assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_load |=> !sfr_load);

  assert_load_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_load |-> core_rst);

  assert_reset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (pcon_rdata == 8'h00));

  assert_idle_clocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pcon_rdata[0] && !pcon_rdata[1]) |->
      (!cpu_clk_en && periph_clk_en && osc_run_en && strobe_hold_en && strobe_hold_lvl));

  assert_idle_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pcon_rdata[0] && !pcon_rdata[1] && int_pend && !core_rst) |=> !pcon_rdata[0]);

  assert_down_clocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcon_rdata[1] |-> (!cpu_clk_en && !periph_clk_en && strobe_hold_en && !strobe_hold_lvl));

  assert_down_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcon_rdata[1] |=> (pcon_rdata[1] || $past(core_rst)));

  assert_osc_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run_en |-> (pcon_rdata[1] && !rst_pin));

  assert_idle_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pcon_rdata[0] && pcon_we && !int_pend && !core_rst) |=> $stable(pcon_rdata));
endmodule

bind rpm_ctrl rpm_ctrl_chk i_chk (.*);

// File: tb/test_rpm_ctrl.sv
module test_rpm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic       pcon_we = 1'b0;
  logic [7:0] pcon_wdata = 8'h00;
  logic       int_pend = 1'b0;
  logic [7:0] pcon_rdata;
  logic       core_rst, sfr_load, cpu_clk_en, periph_clk_en, osc_run_en;
  logic       strobe_hold_en, strobe_hold_lvl;

  int   total = 0;
  int   bad = 0;
  int   nload = 0;
  bit   done = 1'b0;
  logic [7:0] pm;

  rpm_ctrl i_rpm_ctrl (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (sfr_load) nload++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {cpu, periph, osc, hold_en, hold_lvl} expected for a control byte, pin low
  function automatic logic [4:0] exp_ctl(input logic [7:0] p);
    if (p[1])      return 5'b00010;
    else if (p[0]) return 5'b01111;
    else           return 5'b11100;
  endfunction

  task automatic chk_ctl(input string req);
    chk(req, {27'd0, cpu_clk_en, periph_clk_en, osc_run_en, strobe_hold_en, strobe_hold_lvl},
        {27'd0, exp_ctl(pm)});
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    pcon_we = 1'b1;
    pcon_wdata = d;
    @(negedge clk);
    pcon_we = 1'b0;
  endtask

  task automatic irq;
    @(negedge clk);
    int_pend = 1'b1;
    @(negedge clk);
    int_pend = 1'b0;
  endtask

  // long pulse: expects exactly one load and a cleared byte
  task automatic long_pulse(input int len, input string req);
    int start;
    start = nload;
    @(negedge clk);
    rst_pin = 1'b1;
    #1;
    chk({req, " osc on pin (R9)"}, {31'd0, osc_run_en}, 32'd1);
    repeat (len) @(negedge clk);
    chk({req, " core_rst held (R2)"}, {31'd0, core_rst}, 32'd1);
    rst_pin = 1'b0;
    repeat (40) @(negedge clk);
    chk({req, " one load pulse (R2)"}, nload - start, 32'd1);
    chk({req, " reset released (R2)"}, {31'd0, core_rst}, 32'd0);
    pm = 8'h00;
    chk({req, " byte cleared (R4)"}, {24'd0, pcon_rdata}, {24'd0, pm});
    chk_ctl({req, " run clocks (R4)"});
  endtask

  task automatic short_pulse(input int len);
    int start;
    start = nload;
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (len) @(negedge clk);
    rst_pin = 1'b0;
    repeat (30) @(negedge clk);
    chk("R3 no load", nload - start, 32'd0);
    chk("R3 no core_rst", {31'd0, core_rst}, 32'd0);
    chk("R3 byte kept", {24'd0, pcon_rdata}, {24'd0, pm});
  endtask

  task automatic enter_and_leave(input logic [7:0] d);
    wr(d);
    pm = d & 8'h8F;
    chk("R5 write readback", {24'd0, pcon_rdata}, {24'd0, pm});
    if (pm[1]) begin
      chk_ctl("R8 down clocks");
      irq();
      chk("R9 irq ignored in down", {24'd0, pcon_rdata}, {24'd0, pm});
      chk_ctl("R9 still down");
      long_pulse(40, "R9 down exit");
    end else if (pm[0]) begin
      chk_ctl("R6 idle clocks");
      wr(8'($urandom));
      chk("R10 write ignored", {24'd0, pcon_rdata}, {24'd0, pm});
      irq();
      pm[0] = 1'b0;
      chk("R7 wake clears bit0", {24'd0, pcon_rdata}, {24'd0, pm});
      chk_ctl("R7 cpu runs");
    end else begin
      chk_ctl("R5 run clocks");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_C0DE));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pm = 8'h00;
    chk("R1 byte", {24'd0, pcon_rdata}, 32'h0);
    chk_ctl("R1 clocks");
    chk("R1 no reset", {30'd0, core_rst, sfr_load}, 32'd0);

    // directed corners
    wr(8'h8C); pm = 8'h8C;
    chk("R5 flags and spare", {24'd0, pcon_rdata}, 32'h8C);
    wr(8'h70); pm = 8'h00;
    chk("R5 unused read zero", {24'd0, pcon_rdata}, 32'h00);
    wr(8'h0D); pm = 8'h0D;
    chk_ctl("R6 idle");
    wr(8'h02);
    chk("R10 no down from idle", {24'd0, pcon_rdata}, 32'h0D);
    irq(); pm = 8'h0C;
    chk("R7 wake keeps flags", {24'd0, pcon_rdata}, 32'h0C);
    wr(8'h03); pm = 8'h03;
    chk_ctl("R8 both bits down");
    irq();
    chk("R9 irq no exit", {24'd0, pcon_rdata}, 32'h03);
    long_pulse(40, "R9 exit");
    wr(8'h8C); pm = 8'h8C;
    short_pulse(11);
    short_pulse(1);
    long_pulse(36, "R4 flags reset");

    // random mix
    for (int it = 0; it < 30; it++) begin
      case ($urandom % 3)
        0: enter_and_leave(8'($urandom));
        1: short_pulse(1 + int'($urandom % 11));
        default: long_pulse(36 + int'($urandom % 25), "R2 random");
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule